// File: doc/BRIEF.md
# Paged Storage Window Read Controller

This block puts a 1024-byte storage array behind a 256-byte register space. The upper half of the register space (0x80 to 0xFF) is a 128-byte window, and a page-select register in the lower half chooses which of eight pages the window shows. A bus read names an 8-bit register address. For a window address, the controller joins the page field and the offset into a 10-bit storage address and reads one byte from an internal synchronous RAM model. The byte returns one cycle later with a valid strobe.

A read can be issued as a burst continuation. The controller then reads the byte after the previous one. The offset advances inside the current half of the register space and wraps at the 128-byte edge instead of moving into the next page. The software driving the bus must rewrite the page-select register to go further. The window is read-only from the bus. Only the page-select register accepts writes.

Top module: `pwin_ctrl`

## Requirements
- R1: After reset, the page-select register holds 0 (page 0, 1-byte addressing) and `rsp_valid` is low.
- R2: A write to address 0x0B stores `req_wdata[3:0]` in the page-select register, where bits [2:0] are the page and bit 3 is the addressing-mode flag (0 means 1-byte addressing). A read of 0x0B returns the stored 4 bits with bits [7:4] at zero.
- R3: A read of address A in the range 0x80 to 0xFF returns the storage byte at address {page[2:0], A[6:0]}. The storage byte at address S is (S[7:0] + 0x3B * S[9:7]) modulo 256.
- R4: Every read request, whether a start or a continuation, gets exactly one `rsp_valid` pulse in the next cycle, with the data on `rsp_data`. A write or an idle cycle gives no `rsp_valid` in the next cycle.
- R5: A continuation (`req_next` high) reads address {H, (O+1) mod 128}, where H is bit 7 and O is bits [6:0] of the previous read address. A continuation after offset 0x7F goes back to offset 0x00 of the same page.
- R6: Every window read uses the page-select value present in its request cycle. A page-select write made between two reads of a burst therefore redirects the next continuation to the new page at the next offset.
- R7: Writes to window addresses 0x80 to 0xFF have no effect on storage contents or on the page-select register.
- R8: Reads of lower-half addresses other than 0x0B return 0. Writes to them leave the page-select register unchanged.
- R9: The addressing-mode bit does not take part in storage address formation. Only bits [2:0] choose the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_next | input | 1 | Read continues the burst at the next address; `req_addr` is ignored |
| req_addr | input | 8 | Register address of a write or of a burst-start read |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read request |
| rsp_data | output | 8 | Read data |

## Verification
Every read result is due in the cycle after its request cycle, because the RAM output and the register-read path each pass through a single register. A page-select write is visible to any read issued in the following cycle. The bench drives each request just after a falling edge. It samples `rsp_valid` and `rsp_data` at the next falling edge, which falls after the single rising edge that produces them, and it checks for the absence of a strobe after every write. This holds requests back to back, so burst wrap and mid-burst page changes are checked at full rate.

// File: rtl/pwin_pkg.sv
package pwin_pkg;
   // decoded request kind for one cycle
   typedef enum logic [1:0] {
      REQ_NONE  = 2'd0,
      REQ_WRITE = 2'd1,
      REQ_START = 2'd2,
      REQ_CONT  = 2'd3
   } req_kind_e;

   function automatic req_kind_e classify(input logic v, input logic w, input logic n);
      if (!v)      return REQ_NONE;
      else if (w)  return REQ_WRITE;
      else if (n)  return REQ_CONT;
      else         return REQ_START;
   endfunction
endpackage

// File: rtl/pwin_sel_reg.sv
module pwin_sel_reg #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned MODE_W   = 4,
   parameter int unsigned SEL_ADDR = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [MODE_W-1:0] sel_q
);
   generate
      if (MODE_W > DATA_W) begin : g_bad_w
         $error("pwin_sel_reg: MODE_W exceeds DATA_W");
      end
   endgenerate

   logic hit;
   assign hit = wr_en && (wr_addr == ADDR_W'(SEL_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sel_q <= '0;
      else if (hit) sel_q <= wr_data[MODE_W-1:0];
   end
endmodule

// File: rtl/pwin_ptr.sv
module pwin_ptr #(
   parameter int unsigned OFF_BITS = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_start,
   input  logic                rd_cont,
   input  logic [OFF_BITS:0]   start_addr,
   output logic [OFF_BITS:0]   eff_addr
);
   localparam int unsigned AW = OFF_BITS + 1;

   logic [AW-1:0]       last_q;
   logic [OFF_BITS-1:0] step_off;

   // offset wraps inside the half; the half bit is carried unchanged
   assign step_off = last_q[OFF_BITS-1:0] + 1'b1;
   assign eff_addr = rd_cont ? {last_q[AW-1], step_off} : start_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  last_q <= '0;
      else if (rd_start || rd_cont) last_q <= eff_addr;
   end
endmodule

// File: rtl/pwin_store.sv
module pwin_store #(
   parameter int unsigned AW        = 10,
   parameter int unsigned PAGE_BITS = 3,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned FILL_STEP = 59
) (
   input  logic              clk,
   input  logic              rd_en,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_q
);
   localparam int unsigned DEPTH  = 1 << AW;
   localparam int unsigned OFF_W  = AW - PAGE_BITS;

   generate
      if (AW > 12) begin : g_too_big
         $error("pwin_store: array too large for a model");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];

   // computed fill: low address byte plus a per-page step
   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         mem[i] = DATA_W'(i) + DATA_W'(FILL_STEP * (i >> OFF_W));
      end
   end

   always_ff @(posedge clk) begin
      if (rd_en) rd_q <= mem[rd_addr];
   end
endmodule

// File: rtl/pwin_ctrl.sv
module pwin_ctrl #(
   parameter int unsigned PAGE_BITS = 3,
   parameter int unsigned OFF_BITS  = 7,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned SEL_ADDR  = 11,
   parameter int unsigned FILL_STEP = 59
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_next,
   input  logic [7:0]        req_addr,
   input  logic [7:0]        req_wdata,
   output logic              rsp_valid,
   output logic [7:0]        rsp_data
);
   import pwin_pkg::*;

   localparam int unsigned ADDR_W   = OFF_BITS + 1;
   localparam int unsigned MODE_W   = PAGE_BITS + 1;
   localparam int unsigned STORE_AW = PAGE_BITS + OFF_BITS;

   generate
      if (ADDR_W != 8 || DATA_W != 8) begin : g_bus_w
         $error("pwin_ctrl: bus is 8-bit address, 8-bit data");
      end
      if (SEL_ADDR >= (1 << OFF_BITS)) begin : g_sel_pos
         $error("pwin_ctrl: select register must sit in the lower half");
      end
   endgenerate

   req_kind_e kind;
   logic rd_start, rd_cont, rd_any, wr_en;
   assign kind     = classify(req_valid, req_write, req_next);
   assign rd_start = (kind == REQ_START);
   assign rd_cont  = (kind == REQ_CONT);
   assign rd_any   = rd_start || rd_cont;
   assign wr_en    = (kind == REQ_WRITE);

   logic [MODE_W-1:0] sel_q;
   logic [ADDR_W-1:0] eff_addr;

   pwin_sel_reg #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_W(MODE_W), .SEL_ADDR(SEL_ADDR)
   ) i_sel (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
      .wr_addr(req_addr), .wr_data(req_wdata), .sel_q(sel_q)
   );

   pwin_ptr #(.OFF_BITS(OFF_BITS)) i_ptr (
      .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_cont(rd_cont),
      .start_addr(req_addr), .eff_addr(eff_addr)
   );

   logic                win_hit, sel_hit;
   logic                st_rd_en;
   logic [STORE_AW-1:0] st_rd_addr;
   logic [DATA_W-1:0]   st_q;

   assign win_hit    = eff_addr[ADDR_W-1];
   assign sel_hit    = (eff_addr == ADDR_W'(SEL_ADDR));
   assign st_rd_en   = rd_any && win_hit;
   // only the page bits join the address; the mode bit stays out
   assign st_rd_addr = {sel_q[PAGE_BITS-1:0], eff_addr[OFF_BITS-1:0]};

   pwin_store #(
      .AW(STORE_AW), .PAGE_BITS(PAGE_BITS), .DATA_W(DATA_W), .FILL_STEP(FILL_STEP)
   ) i_store (
      .clk(clk), .rd_en(st_rd_en), .rd_addr(st_rd_addr), .rd_q(st_q)
   );

   logic              vld_q, win_q;
   logic [DATA_W-1:0] reg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         win_q <= 1'b0;
         reg_q <= '0;
      end else begin
         vld_q <= rd_any;
         if (rd_any) begin
            win_q <= win_hit;
            reg_q <= sel_hit ? DATA_W'(sel_q) : '0;
         end
      end
   end

   assign rsp_valid = vld_q;
   assign rsp_data  = win_q ? st_q : reg_q;
endmodule

// File: rtl/pwin_chk.sv
module pwin_chk #(
   parameter int unsigned PAGE_BITS = 3,
   parameter int unsigned OFF_BITS  = 7,
   parameter int unsigned SEL_ADDR  = 11
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          req_valid,
   input logic                          req_write,
   input logic                          req_next,
   input logic [7:0]                    req_addr,
   input logic [7:0]                    req_wdata,
   input logic                          rsp_valid,
   input logic [PAGE_BITS:0]            sel_q,
   input logic                          st_rd_en,
   input logic [PAGE_BITS+OFF_BITS-1:0] st_rd_addr
);
   localparam int unsigned SAW = PAGE_BITS + OFF_BITS;

   logic                is_rd;
   logic                prev_win;
   logic [OFF_BITS-1:0] prev_off;
   assign is_rd = req_valid && !req_write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_win <= 1'b0;
         prev_off <= '0;
      end else if (is_rd) begin
         prev_win <= st_rd_en;
         prev_off <= st_rd_addr[OFF_BITS-1:0];
      end
   end

   // R4
   rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_rd |=> rsp_valid);
   // R4
   no_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !is_rd |=> !rsp_valid);
   // R2
   sel_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr == 8'(SEL_ADDR))
      |=> sel_q == $past(req_wdata[PAGE_BITS:0]));
   // R7
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr != 8'(SEL_ADDR)) |=> $stable(sel_q));
   // R6
   page_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_rd_en |-> st_rd_addr[SAW-1:OFF_BITS] == sel_q[PAGE_BITS-1:0]);
   // R3
   win_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && !req_next && req_addr[7])
      |-> (st_rd_en && st_rd_addr[OFF_BITS-1:0] == req_addr[OFF_BITS-1:0]));
   // R5
   off_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && req_next && prev_win)
      |-> (st_rd_en && st_rd_addr[OFF_BITS-1:0] == OFF_BITS'(prev_off + 1'b1)));
endmodule

bind pwin_ctrl pwin_chk #(
   .PAGE_BITS(PAGE_BITS), .OFF_BITS(OFF_BITS), .SEL_ADDR(SEL_ADDR)
) i_pwin_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_next(req_next), .req_addr(req_addr), .req_wdata(req_wdata),
   .rsp_valid(rsp_valid), .sel_q(sel_q), .st_rd_en(st_rd_en),
   .st_rd_addr(st_rd_addr)
);

// File: tb/test_pwin_ctrl.sv
module test_pwin_ctrl;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0, req_write = 1'b0, req_next = 1'b0;
   logic [7:0] req_addr = '0, req_wdata = '0;
   logic       rsp_valid;
   logic [7:0] rsp_data;

   int n_cmp = 0;
   int n_bad = 0;

   // bench model state
   logic [3:0] m_sel = '0;
   logic [7:0] m_last = '0;

   always #(CLK_P/2) clk = ~clk;

   pwin_ctrl i_pwin_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_next(req_next), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data)
   );

   function automatic logic [7:0] store_byte(input logic [9:0] s);
      return 8'(s[7:0] + 8'h3B * s[9:7]);
   endfunction

   function automatic logic [7:0] exp_read(input logic [7:0] a, input logic [3:0] sel);
      if (a[7])          return store_byte({sel[2:0], a[6:0]});
      else if (a == 8'h0B) return {4'h0, sel};
      else               return 8'h00;
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one request cycle, response checked at the next falling edge
   task automatic op_write(input logic [7:0] a, input logic [7:0] d, input string tag);
      req_valid = 1'b1; req_write = 1'b1; req_next = 1'b0; req_addr = a; req_wdata = d;
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      if (a == 8'h0B) m_sel = d[3:0];
      check({tag, " no strobe after write"}, {15'd0, rsp_valid}, 16'd0);
   endtask

   task automatic op_read(input logic [7:0] a, input logic nxt, input string tag);
      logic [7:0] ea;
      logic [7:0] exp;
      ea = nxt ? {m_last[7], 7'(m_last[6:0] + 7'd1)} : a;
      exp = exp_read(ea, m_sel);
      req_valid = 1'b1; req_write = 1'b0; req_next = nxt; req_addr = a;
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0; req_next = 1'b0;
      m_last = ea;
      check(tag, {7'd0, rsp_valid, rsp_data}, {8'h01, exp});
   endtask

   initial begin
      #(CLK_P * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check("R1 strobe low in reset", {15'd0, rsp_valid}, 16'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 strobe low after reset", {15'd0, rsp_valid}, 16'd0);
      op_read(8'h0B, 1'b0, "R1 select reads zero");
      op_read(8'h80, 1'b0, "R3 page0 first byte");

      op_write(8'h0B, 8'hFF, "R2");
      op_read(8'h0B, 1'b0, "R2 upper bits zero");
      op_read(8'h85, 1'b0, "R9 mode bit set, page 7");
      op_write(8'h0B, 8'h05, "R2");
      op_read(8'hC0, 1'b0, "R9 mode clear, page 5");

      op_read(8'hFE, 1'b0, "R5 near page end");
      op_read(8'h00, 1'b1, "R5 offset 7F");
      op_read(8'h00, 1'b1, "R5 wrap to 00 same page");
      op_read(8'h00, 1'b1, "R5 offset 01");

      op_read(8'h90, 1'b0, "R6 before switch");
      op_write(8'h0B, 8'h02, "R6");
      op_read(8'h00, 1'b1, "R6 continuation on new page");

      op_write(8'h91, 8'hAA, "R7");
      op_read(8'h91, 1'b0, "R7 window byte unchanged");
      op_read(8'h0B, 1'b0, "R7 select unchanged");

      op_write(8'h0C, 8'h07, "R8");
      op_read(8'h0B, 1'b0, "R8 select unchanged");
      op_read(8'h0C, 1'b0, "R8 other register reads zero");
      op_read(8'h7E, 1'b0, "R8 lower half start");
      op_read(8'h00, 1'b1, "R5 lower-half continuation");
      op_read(8'h00, 1'b1, "R5 lower-half wrap");

      // full-page burst, 130 bytes from mid page
      op_write(8'h0B, 8'h0E, "R2");
      op_read(8'hF0, 1'b0, "R3 burst start");
      for (int i = 0; i < 130; i++) op_read(8'h00, 1'b1, "R5 long burst");

      // random mix
      for (int i = 0; i < 600; i++) begin
         int unsigned r;
         logic [7:0] a, d;
         r = $urandom % 10;
         a = 8'($urandom);
         d = 8'($urandom);
         if (r < 2)       op_write(8'h0B, d, "R2 random");
         else if (r == 2) op_write(a, d, "R7 R8 random write");
         else if (r < 6)  op_read(a, 1'b0, "R3 R4 random read");
         else             op_read(a, 1'b1, "R5 R6 random burst");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule